// File: doc/BRIEF.md
# Quadword Lane-Merge Execution Slice

This block is one execution slice of a vector datapath. It holds a file of sixteen 256-bit vector registers and carries out one operation on them: it takes the low 64-bit quadword of a source register and places it in bits 127:64 of a destination register. The operation comes in two encodings, selected per request. The legacy two-operand form writes only that quadword and leaves the rest of the destination as it was. The VEX three-operand form builds a fresh value: its low quadword comes from a first source, bits 127:64 come from the low quadword of a second source, and bits 255:128 are cleared.

A decoded request is presented for one cycle with a valid strobe. Sources are read combinationally in that cycle, and the result is written on the next rising edge. A `done` pulse follows every request. A request that is not a legal form of the operation writes nothing and raises `fault` alongside `done`. Illegal forms are a VEX request with the length bit set, and any request whose source operand is in memory. Register indices are four bits wide. When 64-bit mode is off, the top index bit is ignored, so only registers 0 to 7 can be reached.

A debug port reads any register combinationally and can also load a register. It is the only way values are placed in the file from outside.

Top module: `lane_merge_unit`

## Requirements
- R1: Legacy form (`req_vex`=0): after the edge that samples the request, destination bits 127:64 equal source-2 bits 63:0, and destination bits 63:0 keep their previous value.
- R2: Legacy form: destination bits 255:128 keep their previous value, and `req_long` has no effect, so a legacy request with `req_long`=1 completes without fault.
- R3: VEX form (`req_vex`=1, `req_long`=0): destination bits 63:0 take source-1 bits 63:0, and bits 127:64 take source-2 bits 63:0.
- R4: VEX form: destination bits 255:128 are written as zero.
- R5: A VEX request with `req_long`=1 raises `fault` and leaves every register unchanged.
- R6: A request with `req_mem_src`=1, in either form, raises `fault` and leaves every register unchanged.
- R7: With `req_mode64`=0, bit 3 of each of `req_dst`, `req_src1` and `req_src2` is treated as 0, so index 9 addresses register 1. With `req_mode64`=1 all four bits are used.
- R8: `done` is high for exactly the one cycle after each cycle in which `req_valid` is high. `fault` is high only together with such a `done`, for a faulting request. Both are low in any cycle that does not follow a request.
- R9: When the destination index equals a source index, the result is built from that register's value before the write.
- R10: Requests on consecutive cycles each complete. The second one reads the register contents the first one left.
- R11: Synchronous reset (`rst`=1 at an edge) clears all registers to zero and drives `done` and `fault` low.
- R12: `dbg_rdata` shows register `dbg_idx` combinationally. `dbg_we`=1 loads `dbg_wdata` into that register at the edge. An operation writing the same register at the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_vex | input | 1 | Form select: 0 legacy two-operand, 1 VEX three-operand |
| req_long | input | 1 | VEX length bit; 1 is illegal for the VEX form |
| req_mem_src | input | 1 | Source operand is memory (always illegal) |
| req_mode64 | input | 1 | 64-bit mode; 0 masks index bit 3 |
| req_dst | input | 4 | Destination register index |
| req_src1 | input | 4 | First source index (VEX low quadword) |
| req_src2 | input | 4 | Source whose low quadword lands in bits 127:64 |
| dbg_idx | input | 4 | Debug register index |
| dbg_we | input | 1 | Debug load strobe |
| dbg_wdata | input | 256 | Debug load data |
| dbg_rdata | output | 256 | Debug read data, combinational |
| done | output | 1 | Request-completed pulse |
| fault | output | 1 | Invalid-opcode pulse, with done |

## Verification
A wrong register value appears at `dbg_rdata` as soon as the bench points the debug index at that register after the write edge. So every request is followed by a scan of all sixteen registers against a model built from the requirements. That scan also catches a stray write to a register that should not have changed. It covers a faulting request that writes anyway and a masked index that lands on the wrong register. A stale or lost write shows up one request later, when a back-to-back or aliased request reads the register and produces a value that differs from the model. The `done` and `fault` pulses are checked in the single cycle after each request.

// File: rtl/lmu_pkg.sv
`timescale 1ns/1ps
package lmu_pkg;

  typedef enum logic {
    FORM_LEGACY = 1'b0,
    FORM_VEX    = 1'b1
  } form_e;

  typedef struct packed {
    logic write;       // legal request, commit result
    logic fault;       // illegal request, raise fault
    logic clear_upper; // zero everything above the merged half
  } op_ctrl_t;

endpackage

// File: rtl/lmu_regfile.sv
`timescale 1ns/1ps
module lmu_regfile #(
  parameter int NREGS = 16,
  parameter int VW    = 256,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] ra_idx,
  output logic [VW-1:0]   ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [VW-1:0]   rb_data,
  input  logic [IDXW-1:0] rc_idx,
  output logic [VW-1:0]   rc_data,
  input  logic            op_we,
  input  logic [IDXW-1:0] op_idx,
  input  logic [VW-1:0]   op_data,
  input  logic            ld_we,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [VW-1:0]   ld_data
);

  logic [VW-1:0] regs [NREGS];

  // one write process per register; the operation port wins over the load port
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[r] <= '0;
      end else if (op_we && op_idx == IDXW'(r)) begin
        regs[r] <= op_data;
      end else if (ld_we && ld_idx == IDXW'(r)) begin
        regs[r] <= ld_data;
      end
    end
  end

  // combinational reads return the value held before this cycle's edge
  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rc_data = regs[rc_idx];

endmodule

// File: rtl/lmu_decode.sv
`timescale 1ns/1ps
module lmu_decode #(
  parameter int IDXW = 4
) (
  input  logic              req_valid,
  input  logic              req_vex,
  input  logic              req_long,
  input  logic              req_mem_src,
  input  logic              req_mode64,
  input  logic [IDXW-1:0]   req_dst,
  input  logic [IDXW-1:0]   req_src1,
  input  logic [IDXW-1:0]   req_src2,
  output logic [IDXW-1:0]   rd_a_idx,
  output logic [IDXW-1:0]   rd_b_idx,
  output logic [IDXW-1:0]   wr_idx,
  output lmu_pkg::op_ctrl_t ctrl
);
  import lmu_pkg::*;

  form_e form;
  logic  illegal;
  logic [IDXW-1:0] dst_eff, s1_eff, s2_eff;

  // the extension bit is only reachable in 64-bit mode
  function automatic logic [IDXW-1:0] reach(input logic [IDXW-1:0] idx, input logic m64);
    return {idx[IDXW-1] & m64, idx[IDXW-2:0]};
  endfunction

  assign form    = form_e'(req_vex);
  assign dst_eff = reach(req_dst,  req_mode64);
  assign s1_eff  = reach(req_src1, req_mode64);
  assign s2_eff  = reach(req_src2, req_mode64);

  always_comb begin
    illegal = req_mem_src;
    if (form == FORM_VEX && req_long) illegal = 1'b1;
  end

  // port A supplies the bits that are not taken from source 2:
  // the destination itself (legacy) or the first source (VEX)
  assign rd_a_idx = (form == FORM_VEX) ? s1_eff : dst_eff;
  assign rd_b_idx = s2_eff;
  assign wr_idx   = dst_eff;

  assign ctrl.write       = req_valid & ~illegal;
  assign ctrl.fault       = req_valid &  illegal;
  assign ctrl.clear_upper = (form == FORM_VEX);

endmodule

// File: rtl/lmu_merge.sv
`timescale 1ns/1ps
module lmu_merge #(
  parameter int VW    = 256,
  parameter int LANEW = 64,
  localparam int NLANES = VW / LANEW
) (
  input  logic [VW-1:0] a_data,
  input  logic [VW-1:0] b_data,
  input  logic          clear_upper,
  output logic [VW-1:0] result
);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign result[LANEW-1:0] = a_data[LANEW-1:0];
    end else if (g == 1) begin : g_moved
      assign result[2*LANEW-1:LANEW] = b_data[LANEW-1:0];
    end else begin : g_upper
      assign result[(g+1)*LANEW-1:g*LANEW] =
        clear_upper ? '0 : a_data[(g+1)*LANEW-1:g*LANEW];
    end
  end

endmodule

// File: rtl/lane_merge_unit.sv
`timescale 1ns/1ps
module lane_merge_unit #(
  parameter int NREGS = 16,
  parameter int VW    = 256,
  parameter int LANEW = 64,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_vex,
  input  logic            req_long,
  input  logic            req_mem_src,
  input  logic            req_mode64,
  input  logic [IDXW-1:0] req_dst,
  input  logic [IDXW-1:0] req_src1,
  input  logic [IDXW-1:0] req_src2,
  input  logic [IDXW-1:0] dbg_idx,
  input  logic            dbg_we,
  input  logic [VW-1:0]   dbg_wdata,
  output logic [VW-1:0]   dbg_rdata,
  output logic            done,
  output logic            fault
);
  import lmu_pkg::*;

  logic [IDXW-1:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [VW-1:0]   a_data, b_data, merged;
  op_ctrl_t        ctrl;

  lmu_decode #(.IDXW(IDXW)) u_dec (
    .req_valid  (req_valid),
    .req_vex    (req_vex),
    .req_long   (req_long),
    .req_mem_src(req_mem_src),
    .req_mode64 (req_mode64),
    .req_dst    (req_dst),
    .req_src1   (req_src1),
    .req_src2   (req_src2),
    .rd_a_idx   (rd_a_idx),
    .rd_b_idx   (rd_b_idx),
    .wr_idx     (wr_idx),
    .ctrl       (ctrl)
  );

  lmu_regfile #(.NREGS(NREGS), .VW(VW)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_idx (rd_a_idx),
    .ra_data(a_data),
    .rb_idx (rd_b_idx),
    .rb_data(b_data),
    .rc_idx (dbg_idx),
    .rc_data(dbg_rdata),
    .op_we  (ctrl.write),
    .op_idx (wr_idx),
    .op_data(merged),
    .ld_we  (dbg_we),
    .ld_idx (dbg_idx),
    .ld_data(dbg_wdata)
  );

  lmu_merge #(.VW(VW), .LANEW(LANEW)) u_mrg (
    .a_data     (a_data),
    .b_data     (b_data),
    .clear_upper(ctrl.clear_upper),
    .result     (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= req_valid;
      fault <= ctrl.fault;
    end
  end

endmodule

// File: rtl/lmu_checker.sv
`timescale 1ns/1ps
module lmu_checker #(
  parameter int VW    = 256,
  parameter int LANEW = 64,
  parameter int IDXW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_vex,
  input logic            req_long,
  input logic            req_mem_src,
  input logic            req_mode64,
  input logic [IDXW-1:0] req_dst,
  input logic [IDXW-1:0] dbg_idx,
  input logic            dbg_we,
  input logic [VW-1:0]   dbg_rdata,
  input logic            done,
  input logic            fault
);

  logic [IDXW-1:0] dst_seen;
  logic            bad_req;
  assign dst_seen = req_mode64 ? req_dst : (req_dst & {1'b0, {(IDXW-1){1'b1}}});
  assign bad_req  = req_mem_src | (req_vex & req_long);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!done && !fault));
  p_fault_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);
  p_len_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_vex && req_long) |=> fault);
  p_mem_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mem_src) |=> fault);
  p_legacy_len_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_vex && !req_mem_src) |=> !fault);
  p_legacy_low_kept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_vex && !req_mem_src && !dbg_we && dbg_idx == dst_seen)
    |=> (dbg_idx != $past(dbg_idx) || dbg_rdata[LANEW-1:0] == $past(dbg_rdata[LANEW-1:0])));
  p_vex_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_vex && !bad_req && dbg_idx == dst_seen)
    |=> (dbg_idx != $past(dbg_idx) || dbg_rdata[VW-1:2*LANEW] == '0));
  p_fault_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_req && !dbg_we)
    |=> (dbg_idx != $past(dbg_idx) || dbg_rdata == $past(dbg_rdata)));
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!done && !fault));

endmodule

bind lane_merge_unit lmu_checker #(.VW(VW), .LANEW(LANEW), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_vex    (req_vex),
  .req_long   (req_long),
  .req_mem_src(req_mem_src),
  .req_mode64 (req_mode64),
  .req_dst    (req_dst),
  .dbg_idx    (dbg_idx),
  .dbg_we     (dbg_we),
  .dbg_rdata  (dbg_rdata),
  .done       (done),
  .fault      (fault)
);

// File: tb/sim_lane_merge_unit.sv
`timescale 1ns/1ps
module sim_lane_merge_unit;

  localparam int NREGS = 16;
  localparam int VW    = 256;
  localparam int NV    = 12;

  // vector: {vex, long, mem_src, mode64, dst, src1, src2}
  localparam logic [15:0] VECS [NV] = '{
    {4'b0001, 4'd3,  4'd0,  4'd5 },  // legacy
    {4'b1001, 4'd4,  4'd6,  4'd7 },  // vex
    {4'b1101, 4'd1,  4'd2,  4'd3 },  // vex long: fault
    {4'b0011, 4'd5,  4'd0,  4'd6 },  // legacy memory source: fault
    {4'b1011, 4'd6,  4'd1,  4'd2 },  // vex memory source: fault
    {4'b0101, 4'd7,  4'd0,  4'd8 },  // legacy with long set: legal
    {4'b0000, 4'd9,  4'd0,  4'd12},  // mode64 off: d1 s4
    {4'b1001, 4'd12, 4'd12, 4'd12},  // vex all alias
    {4'b0001, 4'd8,  4'd0,  4'd8 },  // legacy alias
    {4'b1000, 4'd15, 4'd10, 4'd11},  // vex mode64 off: d7 s2 s3
    {4'b1001, 4'd13, 4'd1,  4'd3 },  // vex
    {4'b0001, 4'd3,  4'd0,  4'd13}   // legacy on earlier result
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0, req_vex = 1'b0, req_long = 1'b0;
  logic            req_mem_src = 1'b0, req_mode64 = 1'b0;
  logic [3:0]      req_dst = '0, req_src1 = '0, req_src2 = '0;
  logic [3:0]      dbg_idx = '0;
  logic            dbg_we = 1'b0;
  logic [VW-1:0]   dbg_wdata = '0;
  logic [VW-1:0]   dbg_rdata;
  logic            done, fault;

  logic [VW-1:0]   model [NREGS];
  int              nchk = 0;
  int              nfail = 0;

  always #2 clk = ~clk;

  lane_merge_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vex(req_vex),
    .req_long(req_long), .req_mem_src(req_mem_src), .req_mode64(req_mode64),
    .req_dst(req_dst), .req_src1(req_src1), .req_src2(req_src2),
    .dbg_idx(dbg_idx), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .done(done), .fault(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] seed(input int r);
    logic [VW-1:0] v;
    for (int j = 0; j < 4; j++)
      v[j*64 +: 64] = {8'(r), 8'(j), 48'h5A3C_9612_E7B1 ^ 48'(r * 977 + j * 131)};
    return v;
  endfunction

  function automatic logic [3:0] reach(input logic [3:0] i, input logic m64);
    return m64 ? i : {1'b0, i[2:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] v);
    if (v[13]) return "R6";
    if (v[15] && v[14]) return "R5";
    if (!v[12]) return "R7";
    if (v[11:8] == v[3:0] || (v[15] && v[11:8] == v[7:4])) return "R9";
    if (v[15]) return "R3 R4";
    if (v[14]) return "R2";
    return "R1 R2";
  endfunction

  // compare every register with the model through the debug read port
  task automatic scan_file(input string tag);
    logic ok = 1'b1;
    logic [VW-1:0] a = '0, e = '0;
    for (int i = 0; i < NREGS; i++) begin
      dbg_idx = 4'(i);
      #0.2;
      if (ok && dbg_rdata !== model[i]) begin
        ok = 1'b0; a = dbg_rdata; e = model[i];
      end
    end
    chk(ok, {tag, " register file"}, a, e);
  endtask

  task automatic drive(input logic [15:0] v);
    req_valid = 1'b1;
    {req_vex, req_long, req_mem_src, req_mode64} = v[15:12];
    req_dst = v[11:8]; req_src1 = v[7:4]; req_src2 = v[3:0];
  endtask

  // apply model effect of a request; returns expected fault
  function automatic bit model_apply(input logic [15:0] v);
    logic [3:0] d, s1, s2;
    logic [VW-1:0] nv;
    d  = reach(v[11:8], v[12]);
    s1 = reach(v[7:4], v[12]);
    s2 = reach(v[3:0], v[12]);
    if (v[13] || (v[15] && v[14])) return 1'b1;
    if (v[15]) nv = {128'b0, model[s2][63:0], model[s1][63:0]};
    else       nv = {model[d][255:128], model[s2][63:0], model[d][63:0]};
    model[d] = nv;
    return 1'b0;
  endfunction

  task automatic run_vec(input logic [15:0] v);
    bit ef;
    drive(v);
    @(posedge clk);
    ef = model_apply(v);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1, "R8 done after request", VW'(done), VW'(1));
    chk(fault === ef, {tag_of(v), " fault"}, VW'(fault), VW'(ef));
    scan_file(tag_of(v));
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && fault === 1'b0, "R11 outputs after reset", VW'({done, fault}), '0);
    rst = 1'b0;
    scan_file("R11 cleared");

    // seed through the debug port
    for (int i = 0; i < NREGS; i++) begin
      dbg_we = 1'b1; dbg_idx = 4'(i); dbg_wdata = seed(i);
      @(posedge clk); model[i] = seed(i);
      @(negedge clk);
    end
    dbg_we = 1'b0;
    chk(done === 1'b0, "R8 no done while idle", VW'(done), '0);
    scan_file("R12 debug load");

    // vector table
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // back-to-back: second reads the first's result (R10)
    begin
      bit f1, f2;
      drive({4'b0001, 4'd2, 4'd0, 4'd9});
      @(posedge clk); f1 = model_apply({4'b0001, 4'd2, 4'd0, 4'd9});
      @(negedge clk);
      chk(done === 1'b1 && fault === f1, "R10 first done", VW'({done, fault}), VW'({1'b1, f1}));
      drive({4'b1001, 4'd14, 4'd2, 4'd2});
      @(posedge clk); f2 = model_apply({4'b1001, 4'd14, 4'd2, 4'd2});
      @(negedge clk);
      req_valid = 1'b0;
      chk(done === 1'b1 && fault === f2, "R10 second done", VW'({done, fault}), VW'({1'b1, f2}));
      scan_file("R10 back-to-back");
    end

    // fault pulse lasts one cycle when followed by a legal request (R8)
    drive({4'b1101, 4'd0, 4'd1, 4'd2});
    @(posedge clk); @(negedge clk);
    chk(fault === 1'b1, "R5 fault pulse", VW'(fault), VW'(1));
    drive({4'b0001, 4'd0, 4'd0, 4'd11});
    @(posedge clk); void'(model_apply({4'b0001, 4'd0, 4'd0, 4'd11}));
    @(negedge clk);
    req_valid = 1'b0;
    chk(fault === 1'b0 && done === 1'b1, "R8 fault one cycle", VW'({done, fault}), VW'(2'b10));
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0 && fault === 1'b0, "R8 quiet after request", VW'({done, fault}), '0);
    scan_file("R1 after pulse test");

    // operation beats debug load on the same register (R12)
    drive({4'b1001, 4'd5, 4'd4, 4'd6});
    dbg_we = 1'b1; dbg_idx = 4'd5; dbg_wdata = {VW{1'b1}};
    @(posedge clk); void'(model_apply({4'b1001, 4'd5, 4'd4, 4'd6}));
    @(negedge clk);
    req_valid = 1'b0; dbg_we = 1'b0;
    scan_file("R12 operation precedence");

    // reset in mid-run (R11)
    drive({4'b0001, 4'd1, 4'd0, 4'd2});
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    chk(done === 1'b0 && fault === 1'b0, "R11 outputs held low", VW'({done, fault}), '0);
    rst = 1'b0;
    scan_file("R11 registers cleared");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule